// File: doc/BRIEF.md
# Event Readout Frame Serializer

This block turns one event's front-end readout into a fixed 36-word stream for a readout link. It emits one 21-bit word per clock. A start strobe captures a full event snapshot into a register. The snapshot holds:
- 32 channels of 12-bit ADC samples with their 8-bit trigger values,
- a bunch-crossing ID and an event ID,
- three status flags.

The block then plays the frame out and holds a busy flag until the last word has left.

Each frame is laid out the same way. Two all-zero words come first. A header word follows, carrying the crossing and event identifiers, and then a control word carrying the status flags. The last 32 words carry one channel each. A channel word holds the ADC sample, the trigger value and an anti-parity bit that makes the number of ones in the word odd. `sof_o` marks the first word of a frame and `eof_o` the last. A downstream link can therefore frame the stream without counting words.

Top module: `readout_frame_ser`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `valid_o`, `sof_o` and `eof_o` are 0 and `word_o` is 0.
- R2: A `start_i` sampled high on a rising edge while `busy_o` is 0 captures all event inputs on that edge. On the next cycle word 0 appears with `sof_o`. Exactly 36 consecutive valid words follow, and `eof_o` is high with word 35 only.
- R3: Words 0 and 1 of every frame are all zeros.
- R4: Word 2 is the header: bits [20:9] hold the captured bunch-crossing ID and bits [8:0] hold the captured event ID.
- R5: Word 3 is the control word: bit 0 holds the derandomiser-empty flag, bit 1 the clock parity bit and bit 2 the calibration-data bit. Bits [20:3] are zero.
- R6: Words 4 to 35 carry channels 0 to 31 in ascending order (channel = word index − 4). Bits [11:0] hold the ADC sample, bits [19:12] the trigger value, and bit 20 is set so that the 21-bit word has an odd number of ones.
- R7: While `busy_o` is high, `start_i` is ignored and changes on the event inputs have no effect on the frame in flight.
- R8: `busy_o` is high from word 0 through word 35 and low in the cycle after word 35. A `start_i` high in that cycle is accepted, so the next `sof_o` comes two cycles after `eof_o`.
- R9: `valid_o` equals `busy_o`, and while `busy_o` is low `word_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture event and begin frame |
| adc_i | input | 384 | 32 ADC samples, channel k at bits [12k+11:12k] |
| trg_i | input | 256 | 32 trigger values, channel k at bits [8k+7:8k] |
| bxid_i | input | 12 | Bunch-crossing ID |
| evtid_i | input | 9 | Event ID |
| derand_empty_i | input | 1 | Derandomiser-empty status flag |
| clk_par_i | input | 1 | Clock parity bit |
| calib_i | input | 1 | Calibration-data flag |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | `word_o` carries a frame word |
| sof_o | output | 1 | First word of frame |
| eof_o | output | 1 | Last word of frame |
| word_o | output | 21 | Frame word |

## Verification
Two events can fall in the same cycle: the end of one frame and the request for the next, and a start or input change arriving while a frame is still being sent. The bench holds `start_i` high with fresh random event inputs throughout whole frames. It then raises `start_i` in the very idle cycle that follows `eof_o`. Each frame is judged word by word against a frame built from the inputs present on the capture edge. The bench also checks the one-cycle idle gap between the two frames.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int unsigned ZERO_LEN = 2;
  localparam int unsigned HEAD_LEN = 4;  // zero words + header + control

  typedef enum logic [1:0] {
    KIND_ZERO,
    KIND_HDR,
    KIND_CTRL,
    KIND_CHAN
  } word_kind_e;
endpackage

// File: rtl/rfs_event_reg.sv
module rfs_event_reg #(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned ADC_W = 12,
  parameter int unsigned TRG_W = 8,
  parameter int unsigned BX_W  = 12,
  parameter int unsigned EVT_W = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [N_CH*ADC_W-1:0]  adc_i,
  input  logic [N_CH*TRG_W-1:0]  trg_i,
  input  logic [BX_W-1:0]        bxid_i,
  input  logic [EVT_W-1:0]       evtid_i,
  input  logic [2:0]             flags_i,
  output logic [N_CH*ADC_W-1:0]  adc_o,
  output logic [N_CH*TRG_W-1:0]  trg_o,
  output logic [BX_W-1:0]        bxid_o,
  output logic [EVT_W-1:0]       evtid_o,
  output logic [2:0]             flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_o   <= '0;
      trg_o   <= '0;
      bxid_o  <= '0;
      evtid_o <= '0;
      flags_o <= '0;
    end else if (load_i) begin
      adc_o   <= adc_i;
      trg_o   <= trg_i;
      bxid_o  <= bxid_i;
      evtid_o <= evtid_i;
      flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer #(
  parameter int unsigned FRAME_LEN = 36,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             sof_o,
  output logic             eof_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic             busy_q;
  logic [CNT_W-1:0] pos_q;

  assign load_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
    end else if (busy_q) begin
      if (pos_q == LAST) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign pos_o  = pos_q;
  assign sof_o  = busy_q && (pos_q == '0);
  assign eof_o  = busy_q && (pos_q == LAST);
endmodule

// File: rtl/rfs_word_mux.sv
module rfs_word_mux
  import rfs_pkg::*;
#(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned ADC_W = 12,
  parameter int unsigned TRG_W = 8,
  parameter int unsigned BX_W  = 12,
  parameter int unsigned EVT_W = 9,
  localparam int unsigned WORD_W    = ADC_W + TRG_W + 1,
  localparam int unsigned FRAME_LEN = N_CH + HEAD_LEN,
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN),
  localparam int unsigned CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   busy_i,
  input  logic [CNT_W-1:0]       pos_i,
  input  logic [N_CH*ADC_W-1:0]  adc_i,
  input  logic [N_CH*TRG_W-1:0]  trg_i,
  input  logic [BX_W-1:0]        bxid_i,
  input  logic [EVT_W-1:0]       evtid_i,
  input  logic [2:0]             flags_i,
  output logic [WORD_W-1:0]      word_o
);
  logic [WORD_W-1:0] chan_word [N_CH];
  logic [CH_W-1:0]   ch_sel;
  word_kind_e        kind;

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    logic [ADC_W-1:0] adc;
    logic [TRG_W-1:0] trg;
    assign adc = adc_i[g*ADC_W +: ADC_W];
    assign trg = trg_i[g*TRG_W +: TRG_W];
    // odd total weight: top bit is the inverted xor of the payload
    assign chan_word[g] = {~(^{trg, adc}), trg, adc};
  end

  always_comb begin
    if (pos_i < CNT_W'(ZERO_LEN))         kind = KIND_ZERO;
    else if (pos_i == CNT_W'(ZERO_LEN))   kind = KIND_HDR;
    else if (pos_i < CNT_W'(HEAD_LEN))    kind = KIND_CTRL;
    else                                  kind = KIND_CHAN;
  end

  assign ch_sel = CH_W'(pos_i - CNT_W'(HEAD_LEN));

  always_comb begin
    word_o = '0;
    if (busy_i) begin
      unique case (kind)
        KIND_ZERO: word_o = '0;
        KIND_HDR:  word_o = WORD_W'({bxid_i, evtid_i});
        KIND_CTRL: word_o = WORD_W'(flags_i);
        KIND_CHAN: word_o = chan_word[ch_sel];
        default:   word_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/readout_frame_ser.sv
module readout_frame_ser
  import rfs_pkg::*;
#(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned ADC_W = 12,
  parameter int unsigned TRG_W = 8,
  parameter int unsigned BX_W  = 12,
  parameter int unsigned EVT_W = 9,
  localparam int unsigned WORD_W    = ADC_W + TRG_W + 1,
  localparam int unsigned FRAME_LEN = N_CH + HEAD_LEN,
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [N_CH*ADC_W-1:0]  adc_i,
  input  logic [N_CH*TRG_W-1:0]  trg_i,
  input  logic [BX_W-1:0]        bxid_i,
  input  logic [EVT_W-1:0]       evtid_i,
  input  logic                   derand_empty_i,
  input  logic                   clk_par_i,
  input  logic                   calib_i,
  output logic                   busy_o,
  output logic                   valid_o,
  output logic                   sof_o,
  output logic                   eof_o,
  output logic [WORD_W-1:0]      word_o
);
  logic                  load;
  logic [CNT_W-1:0]      pos;
  logic [N_CH*ADC_W-1:0] adc_q;
  logic [N_CH*TRG_W-1:0] trg_q;
  logic [BX_W-1:0]       bxid_q;
  logic [EVT_W-1:0]      evtid_q;
  logic [2:0]            flags_q;

  rfs_sequencer #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .busy_o  (busy_o),
    .pos_o   (pos),
    .sof_o   (sof_o),
    .eof_o   (eof_o)
  );

  rfs_event_reg #(
    .N_CH(N_CH), .ADC_W(ADC_W), .TRG_W(TRG_W), .BX_W(BX_W), .EVT_W(EVT_W)
  ) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .adc_i   (adc_i),
    .trg_i   (trg_i),
    .bxid_i  (bxid_i),
    .evtid_i (evtid_i),
    .flags_i ({calib_i, clk_par_i, derand_empty_i}),
    .adc_o   (adc_q),
    .trg_o   (trg_q),
    .bxid_o  (bxid_q),
    .evtid_o (evtid_q),
    .flags_o (flags_q)
  );

  rfs_word_mux #(
    .N_CH(N_CH), .ADC_W(ADC_W), .TRG_W(TRG_W), .BX_W(BX_W), .EVT_W(EVT_W)
  ) u_mux (
    .busy_i  (busy_o),
    .pos_i   (pos),
    .adc_i   (adc_q),
    .trg_i   (trg_q),
    .bxid_i  (bxid_q),
    .evtid_i (evtid_q),
    .flags_i (flags_q),
    .word_o  (word_o)
  );

  assign valid_o = busy_o;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned FRAME_LEN = 36,
  parameter int unsigned WORD_W    = 21,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              valid_o,
  input logic              sof_o,
  input logic              eof_o,
  input logic [WORD_W-1:0] word_o
);
  // independent word position, counted from valid beats
  logic [CNT_W-1:0] beat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                beat_q <= '0;
    else if (valid_o && eof_o)  beat_q <= '0;
    else if (valid_o)           beat_q <= beat_q + 1'b1;
    else                        beat_q <= '0;
  end

  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (sof_o && valid_o));
  assert_sof_pos_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sof_o == (beat_q == '0)));
  assert_eof_pos_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (eof_o == (beat_q == CNT_W'(FRAME_LEN - 1))));
  assert_lead_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && beat_q < CNT_W'(2)) |-> (word_o == '0));
  assert_odd_weight_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && beat_q >= CNT_W'(4)) |-> ($countones(word_o) % 2 == 1));
  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !eof_o) |=> (busy_o && !sof_o));
  assert_gap_after_eof_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !busy_o);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!valid_o && !sof_o && !eof_o && word_o == '0));
  assert_valid_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == busy_o);
endmodule

bind readout_frame_ser rfs_checker #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .sof_o   (sof_o),
  .eof_o   (eof_o),
  .word_o  (word_o)
);

// File: tb/tb_readout_frame_ser.sv
module tb_readout_frame_ser;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 32, ADC_W = 12, TRG_W = 8, BX_W = 12, EVT_W = 9;
  localparam int WORD_W = ADC_W + TRG_W + 1;
  localparam int FRAME_LEN = N_CH + 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [N_CH*ADC_W-1:0] adc_i = '0;
  logic [N_CH*TRG_W-1:0] trg_i = '0;
  logic [BX_W-1:0] bxid_i = '0;
  logic [EVT_W-1:0] evtid_i = '0;
  logic derand_empty_i = 1'b0, clk_par_i = 1'b0, calib_i = 1'b0;
  logic busy_o, valid_o, sof_o, eof_o;
  logic [WORD_W-1:0] word_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [ADC_W-1:0] e_adc [N_CH];
  logic [TRG_W-1:0] e_trg [N_CH];
  logic [BX_W-1:0]  e_bx;
  logic [EVT_W-1:0] e_ev;
  logic [2:0]       e_fl;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  readout_frame_ser dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WORD_W-1:0] exp_word(input int i);
    logic [WORD_W-1:0] w;
    if (i < 2) w = '0;
    else if (i == 2) w = {e_bx, e_ev};
    else if (i == 3) w = WORD_W'(e_fl);
    else begin
      w[ADC_W-1:0] = e_adc[i-4];
      w[ADC_W+TRG_W-1:ADC_W] = e_trg[i-4];
      w[WORD_W-1] = ~(^{e_trg[i-4], e_adc[i-4]});
    end
    return w;
  endfunction

  task automatic scramble();
    for (int k = 0; k < N_CH; k++) begin
      adc_i[k*ADC_W +: ADC_W] = ADC_W'($urandom);
      trg_i[k*TRG_W +: TRG_W] = TRG_W'($urandom);
    end
    bxid_i = BX_W'($urandom);
    evtid_i = EVT_W'($urandom);
    {calib_i, clk_par_i, derand_empty_i} = 3'($urandom);
  endtask

  // mode 0 random, 1 all zero, 2 all ones; call at a negedge with block idle
  task automatic start_frame(input int mode);
    if (mode == 0) scramble();
    else begin
      adc_i = (mode == 2) ? '1 : '0;
      trg_i = (mode == 2) ? '1 : '0;
      bxid_i = (mode == 2) ? '1 : '0;
      evtid_i = (mode == 2) ? '1 : '0;
      {calib_i, clk_par_i, derand_empty_i} = (mode == 2) ? 3'b111 : 3'b000;
    end
    for (int k = 0; k < N_CH; k++) begin
      e_adc[k] = adc_i[k*ADC_W +: ADC_W];
      e_trg[k] = trg_i[k*TRG_W +: TRG_W];
    end
    e_bx = bxid_i;
    e_ev = evtid_i;
    e_fl = {calib_i, clk_par_i, derand_empty_i};
    start_i = 1'b1;
  endtask

  task automatic play(input bit noise);
    @(negedge clk_i);
    for (int i = 0; i < FRAME_LEN; i++) begin
      chk(busy_o && valid_o, "R8/R9 busy and valid in frame", {busy_o, valid_o}, 2'b11);
      chk(sof_o == (i == 0), "R2 sof position", sof_o, (i == 0));
      chk(eof_o == (i == FRAME_LEN-1), "R2 eof position", eof_o, (i == FRAME_LEN-1));
      if (i < 2)       chk(word_o == exp_word(i), "R3 zero word", word_o, exp_word(i));
      else if (i == 2) chk(word_o == exp_word(i), "R4 header", word_o, exp_word(i));
      else if (i == 3) chk(word_o == exp_word(i), "R5 control", word_o, exp_word(i));
      else begin
        chk(word_o == exp_word(i), noise ? "R7 channel word under noise" : "R6 channel word",
            word_o, exp_word(i));
        chk(^word_o == 1'b1, "R6 odd weight", word_o, exp_word(i));
      end
      if (noise) begin start_i = 1'b1; scramble(); end
      else start_i = 1'b0;
      @(negedge clk_i);
    end
    chk(!busy_o && !valid_o && !sof_o && !eof_o, "R8 idle after last word",
        {busy_o, valid_o, sof_o, eof_o}, 0);
    chk(word_o == '0, "R9 idle word zero", word_o, 0);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD*2 + 1);
    chk(!busy_o && !valid_o && !sof_o && !eof_o && word_o == '0, "R1 reset state",
        {busy_o, valid_o, sof_o, eof_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !valid_o, "R9 idle before start", {busy_o, valid_o}, 0);

    start_frame(1);   // all zero: every anti-parity bit must be 1
    play(1'b0);
    start_frame(2);   // all ones, started in the cycle after last word
    play(1'b1);
    for (int f = 0; f < 8; f++) begin
      if (f % 2 == 1) begin
        repeat (2) begin
          @(negedge clk_i);
          chk(!busy_o && word_o == '0, "R9 stays idle", busy_o, 0);
        end
      end
      start_frame(0);
      play(f % 3 == 0);
    end
    // held start: next frame back-to-back with one idle cycle
    start_frame(0);
    play(1'b1);
    start_frame(0);
    play(1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule